// File: doc/BRIEF.md
# SPI Serial RAM Target

This block acts as the target side of an SPI link in clock mode 0. It presents an 8 KiB byte-addressed RAM and a small status register. A host drives chip select low, shifts an opcode in MSB first, and then sends whatever operands the command needs. The block samples MOSI on rising SCK and updates MISO after falling SCK. Raising chip select ends the command.

Memory commands carry a 16-bit address after the opcode: the high byte first, then the low byte. Only the low 13 address bits are used. Data bytes follow, and the address advances after each byte. A write-enable latch guards every write to memory or to the status register. A status bit limits the address advance to the current 32-byte page. SCK, chip select and MOSI are brought into the system clock domain by two-stage synchronizers. SCK must therefore stay at most one quarter of the system clock rate.

Top module: `spi_sram_target`

## Requirements
- R1: Bits are sampled on rising SCK and shifted MSB first. MISO changes only after falling SCK and reads 0 while chip select is high.
- R2: A memory command is the opcode 0x03 (read) or 0x02 (write), then the address high byte, then the address low byte. Only the low 5 bits of the high byte are used, so the address is 13 bits.
- R3: A read returns the stored byte at the address, then one byte per following byte slot from successively higher addresses. With page rollover off, the address after 0x1FFF is 0x0000.
- R4: A write stores each complete data byte at the current address and then advances the address, following the same rule as a read.
- R5: When status bit 5 is 1, an address advance keeps bits 12..5 and increments bits 4..0 modulo 32. Both reads and writes therefore wrap to the start of the same 32-byte page.
- R6: Opcode 0x06 sets the write-enable latch, which reads back as status bit 1 = 1.
- R7: Opcode 0x04 clears the latch at once. While the latch is 0, a memory write (0x02) or a status write (0x01) changes nothing.
- R8: When chip select rises, the latch clears if at least one data byte was accepted in that command, for either memory or status. If no data byte was accepted, the latch is kept.
- R9: Opcode 0x05 returns the status byte, repeated for each further byte slot. Bit 0 (busy) and bit 7 always read 0, bit 1 is the latch, and bits 6..2 are the stored bits. Opcode 0x01 followed by one data byte writes only bits 6..2.
- R10: After reset, status reads 0x00 and MISO is 0. An unknown opcode is ignored, and MISO stays 0 for the rest of that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCK |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock, mode 0 |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |

## Verification
The bench writes a 768-byte burst that runs from 0x1E80 through the top of memory and back past 0x0000. It then reads the burst back. A design that wrapped the address wrongly would store data in the wrong place, or would overwrite the first bytes of the burst. Page rollover is tested with writes and reads that start near the end of a page and run past it. The next page must stay unchanged: a design that let the carry reach bit 5 would corrupt it.

Several write-enable cases are covered:
- A command that carries an address but no data must leave the latch set. A design that cleared it early would reject the next write.
- Writes attempted without the latch must leave both memory and status unchanged.
- A status write of 0xFF must read back as 0x7C, which shows that bits 0, 1 and 7 cannot be written.

// File: rtl/spi_sram_target.sv
module spi_sram_target #(
  parameter int AW = 13,
  parameter int PW = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic miso
);
  localparam int DEPTH = 1 << AW;
  localparam logic [7:0] OP_WREN = 8'h06, OP_WRDI = 8'h04, OP_WRITE = 8'h02,
                         OP_READ = 8'h03, OP_WRSR = 8'h01, OP_RDSR = 8'h05;

  logic [2:0]    sck_q, cs_q;
  logic [1:0]    mo_q;
  logic [2:0]    bits;
  logic [1:0]    ph;
  logic [7:0]    op, shin, shout;
  logic [AW-1:0] addr;
  logic [4:0]    st;
  logic          wel, wrote;
  logic [7:0]    mem [DEPTH];

  wire rise_e = sck_q[1] & ~sck_q[2];
  wire fell_e = ~sck_q[1] & sck_q[2];
  wire sel    = ~cs_q[1];
  wire cs_up  = cs_q[1] & ~cs_q[2];
  wire roll   = st[3];

  wire [7:0] nb   = {shin[6:0], mo_q[1]};
  wire       done = sel & rise_e & (bits == 3'd7);
  wire       dph  = (ph == 2'd3);
  wire       wr_mem = done & dph & (op == OP_WRITE) & wel;
  wire       wr_st  = done & (ph == 2'd1) & (op == OP_WRSR) & wel;
  wire       rd_load = sel & fell_e & (bits == 3'd0) &
                       (((op == OP_READ) & dph) | ((op == OP_RDSR) & (ph != 2'd0)));
  wire       rd_step = rd_load & (op == OP_READ);
  wire       step  = wr_mem | rd_step;
  wire       wrdi  = done & (ph == 2'd0) & (nb == OP_WRDI);
  wire [7:0] sreg  = {1'b0, st, wel, 1'b0};
  wire [AW-1:0] nxt = roll ? {addr[AW-1:PW], addr[PW-1:0] + 1'b1} : addr + 1'b1;

  assign miso = shout[7];

  always_ff @(posedge clk) if (wr_mem) mem[addr] <= nb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '0; cs_q <= '1; mo_q <= '0;
      bits <= '0; ph <= '0; op <= '0; shin <= '0; shout <= '0;
      addr <= '0; st <= '0; wel <= 1'b0; wrote <= 1'b0;
    end else begin
      sck_q <= {sck_q[1:0], sck};
      cs_q  <= {cs_q[1:0], cs_n};
      mo_q  <= {mo_q[0], mosi};
      if (!sel) begin
        bits <= '0; ph <= '0; shout <= '0; wrote <= 1'b0;
        if (cs_up && wrote) wel <= 1'b0;
      end else begin
        if (rise_e) begin
          shin <= nb;
          bits <= bits + 3'd1;
        end
        if (done) begin
          if (!dph) ph <= ph + 2'd1;
          case (ph)
            2'd0: begin
              op <= nb;
              if (nb == OP_WREN) wel <= 1'b1;
              if (nb == OP_WRDI) wel <= 1'b0;
            end
            2'd1: begin
              if (op == OP_READ || op == OP_WRITE) addr[AW-1:8] <= nb[AW-9:0];
              if (wr_st) begin
                st <= nb[6:2];
                wrote <= 1'b1;
              end
            end
            2'd2: if (op == OP_READ || op == OP_WRITE) addr[7:0] <= nb;
            default: if (wr_mem) begin
              addr  <= nxt;
              wrote <= 1'b1;
            end
          endcase
        end
        if (fell_e) begin
          if (bits == 3'd0)
            shout <= rd_load ? ((op == OP_READ) ? mem[addr] : sreg) : 8'h00;
          else
            shout <= {shout[6:0], 1'b0};
          if (rd_step) addr <= nxt;
        end
      end
    end
  end
endmodule

// File: rtl/spi_sram_chk.sv
module spi_sram_chk #(
  parameter int AW = 13,
  parameter int PW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic [1:0]    ph,
  input logic [7:0]    nb,
  input logic          wel,
  input logic [4:0]    st,
  input logic          cs_up,
  input logic          wrote,
  input logic          wrdi,
  input logic          step,
  input logic          roll,
  input logic [AW-1:0] addr
);
  // R6
  wel_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ph == 2'd0 && nb == 8'h06) |=> wel);

  // R7
  wel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ph == 2'd0 && nb == 8'h04) |=> !wel);

  // R7
  st_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wel |=> $stable(st));

  // R8
  wel_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wel) |-> (($past(cs_up) && $past(wrote)) || $past(wrdi)));

  // R5
  page_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && roll) |=> (addr[AW-1:PW] == $past(addr[AW-1:PW])));
endmodule

bind spi_sram_target spi_sram_chk #(.AW(AW), .PW(PW)) chk (
  .clk(clk), .rst_n(rst_n), .done(done), .ph(ph), .nb(nb), .wel(wel),
  .st(st), .cs_up(cs_up), .wrote(wrote), .wrdi(wrdi), .step(step),
  .roll(roll), .addr(addr)
);

// File: tb/tb_spi_sram_target.sv
module tb_spi_sram_target;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso;
  int nvec = 0, nerr = 0;
  logic [7:0] mdl [8192];
  logic       kn  [8192];
  logic       roll = 1'b0;

  spi_sram_target dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck),
                       .mosi(mosi), .miso(miso));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] pat(input int k);
    return 8'((k * 37 + 11) ^ (k >> 8));
  endfunction

  function automatic logic [12:0] adv(input logic [12:0] a);
    return roll ? {a[12:5], a[4:0] + 5'd1} : a + 13'd1;
  endfunction

  task automatic chk(input string rq, input logic [7:0] got, input logic [7:0] exp);
    nvec++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got %02h expected %02h", rq, got, exp);
    end
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic sel_on;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic sel_off;
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic op1(input logic [7:0] o);
    logic [7:0] r;
    sel_on; xbyte(o, r); sel_off;
  endtask

  task automatic rdsr(input string rq, input logic [7:0] exp);
    logic [7:0] r;
    sel_on; xbyte(8'h05, r);
    xbyte(8'h00, r); chk(rq, r, exp);
    xbyte(8'h00, r); chk(rq, r, exp);
    sel_off;
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] r;
    sel_on; xbyte(8'h01, r); xbyte(v, r); sel_off;
  endtask

  task automatic wmem(input logic [15:0] a16, input int n, input int seed, input bit acc);
    logic [7:0] r;
    logic [12:0] a;
    a = a16[12:0];
    sel_on; xbyte(8'h02, r); xbyte(a16[15:8], r); xbyte(a16[7:0], r);
    for (int i = 0; i < n; i++) begin
      xbyte(pat(seed + i), r);
      if (acc) begin
        mdl[a] = pat(seed + i);
        kn[a]  = 1'b1;
      end
      a = adv(a);
    end
    sel_off;
  endtask

  task automatic rmem(input string rq, input logic [12:0] a0, input int n);
    logic [7:0] r;
    logic [12:0] a;
    a = a0;
    sel_on; xbyte(8'h03, r); xbyte({3'b000, a0[12:8]}, r); xbyte(a0[7:0], r);
    for (int i = 0; i < n; i++) begin
      xbyte(8'h00, r);
      if (kn[a]) chk(rq, r, mdl[a]);
      a = adv(a);
    end
    sel_off;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    logic [7:0] r;
    for (int i = 0; i < 8192; i++) kn[i] = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R10 miso after reset", {7'd0, miso}, 8'h00);
    rdsr("R10 R9 reset status", 8'h00);

    op1(8'h06); rdsr("R6 latch set", 8'h02);
    op1(8'h04); rdsr("R7 latch cleared by 0x04", 8'h00);

    // R3 R4 R2 R1: long burst crossing the top of memory
    op1(8'h06);
    wmem(16'h1E80, 768, 0, 1'b1);
    rdsr("R8 latch cleared after write", 8'h00);
    rmem("R3 R4 burst readback and modulo wrap", 13'h1E80, 768);

    // R7: write without latch ignored
    wmem(16'h0005, 4, 500, 1'b0);
    rmem("R7 write without latch ignored", 13'h0000, 16);

    // R8: address only, no data, latch kept
    op1(8'h06);
    sel_on; xbyte(8'h02, r); xbyte(8'h00, r); xbyte(8'h10, r); sel_off;
    rdsr("R8 latch kept without data byte", 8'h02);

    // R2: high address bits above bit 12 ignored
    wmem(16'hE040, 2, 700, 1'b1);
    rmem("R2 upper address bits ignored", 13'h0040, 2);

    // preload two pages, rollover off
    op1(8'h06);
    wmem(16'h0400, 64, 800, 1'b1);

    // R9: status write masks
    op1(8'h06); wrsr(8'hFF);
    rdsr("R9 R8 status write masked, latch cleared", 8'h7C);
    wrsr(8'h00);
    rdsr("R7 status write without latch ignored", 8'h7C);
    roll = 1'b1;

    // R5: rollover write and read
    op1(8'h06);
    wmem(16'h041A, 40, 900, 1'b1);
    rmem("R5 page rollover read", 13'h041E, 34);

    op1(8'h06); wrsr(8'h00);
    rdsr("R9 status cleared", 8'h00);
    roll = 1'b0;
    rmem("R5 neighbour page untouched", 13'h0400, 64);

    // R10: unknown opcode
    sel_on; xbyte(8'hAB, r);
    xbyte(8'h00, r); chk("R10 unknown opcode miso", r, 8'h00);
    xbyte(8'h00, r); chk("R10 unknown opcode miso", r, 8'h00);
    sel_off;
    rdsr("R10 unknown opcode no status change", 8'h00);
    chk("R1 miso idle with cs high", {7'd0, miso}, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule